// File: doc/BRIEF.md
# Late-Result Pipeline Interlock

This block holds the descriptor registers of a five-stage in-order pipeline (decode, address, memory, execute, write-back) and decides when the pipeline must stall. Each descriptor carries a valid bit, a tag, a write mask, a read mask and a coprocessor-store flag. The write mask names the special result registers the instruction produces. The read mask names the ones it reads explicitly while in the memory stage. The flag marks coprocessor-store instructions.

The multiply/divide and MAC result registers receive their new value late in the execute stage, so that value cannot be forwarded back to the memory stage. When the memory-stage instruction needs a register that the execute-stage instruction is writing, the unit stalls for exactly one cycle:
- decode, address and memory hold their contents;
- execute receives an empty slot;
- write-back keeps advancing.

Coprocessor-store instructions never trigger this stall. A driver offers one descriptor per cycle. It is accepted only in a cycle where `stall_o` is low.

Top module: `late_result_interlock`

## Requirements
- R1: A synchronous active-high `rst` clears every stage's valid bit. On the cycle after reset, `stall_o`, `bubble_o`, `mem_valid_o`, `exe_valid_o` and `wb_valid_o` are all 0, even if a stall was pending.
- R2: Without a stall, an accepted descriptor moves one stage per clock.
  - It is in decode after the 1st edge, in memory after the 3rd, in execute after the 4th and in write-back after the 5th.
  - Its tag is visible on `mem_tag_o`, `exe_tag_o` and `wb_tag_o` in those stages.
- R3: `stall_o` is 1 in a cycle when all of these hold: the memory-stage and execute-stage descriptors are both valid, the memory-stage read mask and the execute-stage write mask share a set bit, and the memory-stage instruction is not coprocessor-store.
  - Mask bit positions: 0 multiply/divide low, 1 multiply/divide high, 2 multiply/divide status, 3 MAC accumulator low, 4 MAC accumulator high, 5 MAC status.
- R4: On the edge that ends a stall cycle:
  - decode, address and memory keep their descriptors;
  - execute becomes invalid;
  - write-back takes the old execute descriptor;
  - `bubble_o` is 1 for the following cycle.
- R5: A stall lasts exactly one cycle. On the next edge the waiting reader enters execute.
- R6: A memory-stage reader with the coprocessor-store flag set never stalls, even when its read mask overlaps the producer's write mask.
- R7: A reader whose read mask shares no bit with the execute-stage write mask does not stall.
- R8: No stall occurs when one independent instruction sits between producer and reader, because the producer is in write-back by the time the reader reaches memory.
- R9: No stall occurs when either the producer or the reader descriptor is invalid, whatever their masks.
- R10: When `flush` is 1 on an edge:
  - decode, address and memory become invalid;
  - execute receives an empty slot;
  - `bubble_o` is not raised by the flush.
- R11: A descriptor offered in a cycle where `stall_o` is 1 is dropped and never reaches the memory stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate decode, address and memory stages |
| in_valid | input | 1 | Offered descriptor is valid |
| in_tag | input | TAG_W | Offered descriptor tag |
| in_wr_mask | input | NRES | Result registers written by the offered instruction |
| in_rd_mask | input | NRES | Result registers read explicitly in the memory stage |
| in_cstore | input | 1 | Offered instruction is of the coprocessor-store class |
| stall_o | output | 1 | Front stages hold this cycle; input not accepted |
| bubble_o | output | 1 | Execute holds a stall-inserted empty slot |
| mem_valid_o | output | 1 | Memory stage valid |
| mem_tag_o | output | TAG_W | Memory stage tag |
| exe_valid_o | output | 1 | Execute stage valid |
| exe_tag_o | output | TAG_W | Execute stage tag |
| wb_valid_o | output | 1 | Write-back stage valid |
| wb_tag_o | output | TAG_W | Write-back stage tag |

## Verification
The main function is exercised with four instruction orderings, and each one separates a different case:
- A producer directly followed by a reader of the same register must give one stall, one bubble and a one-cycle delay of every later instruction.
- The same pair with an independent instruction between them must give no stall, which shows that only the memory/execute pair is compared.
- A coprocessor-store reader must pass without stalling.
- Directed sequences with disjoint masks and with an invalid producer or reader show that overlap and validity are both required.

Further directed runs offer a descriptor during a stall, flush a full front end, and reset while a stall is pending. They show that the dropped input never appears and that both flush and reset clear the stages.

// File: rtl/lri_pkg.sv
`timescale 1ns/1ps
package lri_pkg;
    localparam int RES_COUNT = 6;
    localparam int TAG_BITS  = 8;

    typedef enum int {
        RES_MD_LO  = 0,
        RES_MD_HI  = 1,
        RES_MD_ST  = 2,
        RES_ACC_LO = 3,
        RES_ACC_HI = 4,
        RES_ACC_ST = 5
    } res_idx_e;
endpackage

// File: rtl/lri_overlap.sv
`timescale 1ns/1ps
module lri_overlap #(
    parameter int W = lri_pkg::RES_COUNT
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         any_o
);
    logic [W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign hit[i] = a_i[i] & b_i[i];
    end

    assign any_o = |hit;
endmodule

// File: rtl/lri_hazard.sv
`timescale 1ns/1ps
module lri_hazard #(
    parameter int NRES = lri_pkg::RES_COUNT
) (
    input  logic            rd_valid_i,
    input  logic [NRES-1:0] rd_mask_i,
    input  logic            rd_cstore_i,
    input  logic            wr_valid_i,
    input  logic [NRES-1:0] wr_mask_i,
    output logic            hold_o
);
    logic shared;

    lri_overlap #(.W(NRES)) u_ovl (
        .a_i   (rd_mask_i),
        .b_i   (wr_mask_i),
        .any_o (shared)
    );

    // Late-written result cannot be forwarded to the memory stage.
    assign hold_o = rd_valid_i & wr_valid_i & ~rd_cstore_i & shared;
endmodule

// File: rtl/late_result_interlock.sv
`timescale 1ns/1ps
module late_result_interlock #(
    parameter int TAG_W = lri_pkg::TAG_BITS,
    parameter int NRES  = lri_pkg::RES_COUNT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [NRES-1:0]  in_wr_mask,
    input  logic [NRES-1:0]  in_rd_mask,
    input  logic             in_cstore,
    output logic             stall_o,
    output logic             bubble_o,
    output logic             mem_valid_o,
    output logic [TAG_W-1:0] mem_tag_o,
    output logic             exe_valid_o,
    output logic [TAG_W-1:0] exe_tag_o,
    output logic             wb_valid_o,
    output logic [TAG_W-1:0] wb_tag_o
);
    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [NRES-1:0]  wr;
        logic [NRES-1:0]  rd;
        logic             cs;
    } front_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [NRES-1:0]  wr;
    } prod_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
    } retire_t;

    typedef struct packed {
        front_t  dec;
        front_t  adr;
        front_t  mem;
        prod_t   exe;
        retire_t wb;
        logic    bubble;
    } state_t;

    state_t st_q, st_d;
    logic   hold;

    lri_hazard #(.NRES(NRES)) u_haz (
        .rd_valid_i  (st_q.mem.valid),
        .rd_mask_i   (st_q.mem.rd),
        .rd_cstore_i (st_q.mem.cs),
        .wr_valid_i  (st_q.exe.valid),
        .wr_mask_i   (st_q.exe.wr),
        .hold_o      (hold)
    );

    always_comb begin
        st_d = st_q;

        // write-back always advances
        st_d.wb.valid = st_q.exe.valid;
        st_d.wb.tag   = st_q.exe.tag;

        if (hold) begin
            st_d.exe = '0;
        end else begin
            st_d.dec.valid = in_valid;
            st_d.dec.tag   = in_tag;
            st_d.dec.wr    = in_wr_mask;
            st_d.dec.rd    = in_rd_mask;
            st_d.dec.cs    = in_cstore;
            st_d.adr       = st_q.dec;
            st_d.mem       = st_q.adr;
            st_d.exe.valid = st_q.mem.valid;
            st_d.exe.tag   = st_q.mem.tag;
            st_d.exe.wr    = st_q.mem.wr;
        end

        if (flush) begin
            st_d.dec.valid = 1'b0;
            st_d.adr.valid = 1'b0;
            st_d.mem.valid = 1'b0;
            st_d.exe       = '0;
        end

        st_d.bubble = hold;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stall_o     = hold;
    assign bubble_o    = st_q.bubble;
    assign mem_valid_o = st_q.mem.valid;
    assign mem_tag_o   = st_q.mem.tag;
    assign exe_valid_o = st_q.exe.valid;
    assign exe_tag_o   = st_q.exe.tag;
    assign wb_valid_o  = st_q.wb.valid;
    assign wb_tag_o    = st_q.wb.tag;
endmodule

// File: rtl/lri_checker.sv
`timescale 1ns/1ps
module lri_checker #(
    parameter int TAG_W = lri_pkg::TAG_BITS
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             stall_o,
    input logic             bubble_o,
    input logic             mem_valid_o,
    input logic [TAG_W-1:0] mem_tag_o,
    input logic             exe_valid_o,
    input logic [TAG_W-1:0] exe_tag_o,
    input logic             wb_valid_o,
    input logic [TAG_W-1:0] wb_tag_o
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!stall_o && !bubble_o && !mem_valid_o && !exe_valid_o && !wb_valid_o));

    a_r2_exe_to_wb: assert property (@(posedge clk) disable iff (rst)
        exe_valid_o |=> (wb_valid_o && wb_tag_o == $past(exe_tag_o)));

    a_r4_bubble_inserted: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> (bubble_o && !exe_valid_o));

    a_r4_mem_holds: assert property (@(posedge clk) disable iff (rst)
        (stall_o && !flush) |=> (mem_valid_o == $past(mem_valid_o) && mem_tag_o == $past(mem_tag_o)));

    a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> !stall_o);

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!mem_valid_o && !exe_valid_o));
endmodule

bind late_result_interlock lri_checker #(.TAG_W(TAG_W)) u_chk (.*);

// File: tb/late_result_interlock_test.sv
`timescale 1ns/1ps
module late_result_interlock_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flush = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_tag = '0;
    logic [5:0] in_wr_mask = '0;
    logic [5:0] in_rd_mask = '0;
    logic       in_cstore = 1'b0;
    logic       stall_o, bubble_o, mem_valid_o, exe_valid_o, wb_valid_o;
    logic [7:0] mem_tag_o, exe_tag_o, wb_tag_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    late_result_interlock uut (
        .clk(clk), .rst(rst), .flush(flush),
        .in_valid(in_valid), .in_tag(in_tag), .in_wr_mask(in_wr_mask),
        .in_rd_mask(in_rd_mask), .in_cstore(in_cstore),
        .stall_o(stall_o), .bubble_o(bubble_o),
        .mem_valid_o(mem_valid_o), .mem_tag_o(mem_tag_o),
        .exe_valid_o(exe_valid_o), .exe_tag_o(exe_tag_o),
        .wb_valid_o(wb_valid_o), .wb_tag_o(wb_tag_o)
    );

    typedef struct packed {
        logic       iv;
        logic [7:0] it;
        logic [5:0] iw;
        logic [5:0] ir;
        logic       ic;
        logic       e_stall;
        logic       e_bub;
        logic       e_exv;
        logic [7:0] e_ext;
        logic       e_wbv;
        logic [7:0] e_wbt;
    } vec_t;

    localparam int NV = 24;
    // rows 0-8: producer then adjacent reader; 9-16: reordered; 17-23: coprocessor store
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'd1,  6'h01, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0},
        '{1'b1, 8'd2,  6'h00, 6'h01, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0},
        '{1'b1, 8'd3,  6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0},
        '{1'b0, 8'd0,  6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0},
        '{1'b0, 8'd0,  6'h00, 6'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'd1,  1'b0, 8'd0},
        '{1'b0, 8'd0,  6'h00, 6'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0,  1'b1, 8'd1},
        '{1'b0, 8'd0,  6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'd2,  1'b0, 8'd0},
        '{1'b0, 8'd0,  6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'd3,  1'b1, 8'd2},
        '{1'b0, 8'd0,  6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b1, 8'd3},
        '{1'b1, 8'd11, 6'h01, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0},
        '{1'b1, 8'd12, 6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0},
        '{1'b1, 8'd13, 6'h00, 6'h01, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0},
        '{1'b0, 8'd0,  6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0},
        '{1'b0, 8'd0,  6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'd11, 1'b0, 8'd0},
        '{1'b0, 8'd0,  6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'd12, 1'b1, 8'd11},
        '{1'b0, 8'd0,  6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'd13, 1'b1, 8'd12},
        '{1'b0, 8'd0,  6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b1, 8'd13},
        '{1'b1, 8'd21, 6'h08, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0},
        '{1'b1, 8'd22, 6'h00, 6'h08, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0},
        '{1'b0, 8'd0,  6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0},
        '{1'b0, 8'd0,  6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd0},
        '{1'b0, 8'd0,  6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'd21, 1'b0, 8'd0},
        '{1'b0, 8'd0,  6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'd22, 1'b1, 8'd21},
        '{1'b0, 8'd0,  6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b1, 8'd22}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [7:0] t, input logic [5:0] w,
                         input logic [5:0] r, input logic c);
        in_valid = v; in_tag = t; in_wr_mask = w; in_rd_mask = r; in_cstore = c;
    endtask

    task automatic offer(input logic v, input logic [7:0] t, input logic [5:0] w,
                         input logic [5:0] r, input logic c);
        drive(v, t, w, r, c);
        @(negedge clk);
    endtask

    task automatic idle();
        offer(1'b0, 8'd0, 6'h00, 6'h00, 1'b0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: state after reset
        chk("R1 stall", stall_o, 0);
        chk("R1 bubble", bubble_o, 0);
        chk("R1 mem_valid", mem_valid_o, 0);
        chk("R1 exe_valid", exe_valid_o, 0);
        chk("R1 wb_valid", wb_valid_o, 0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            string sreq;
            sreq = (k < 9) ? "R3 stall" : (k < 17) ? "R8 stall" : "R6 stall";
            chk(sreq, stall_o, VEC[k].e_stall);
            chk("R4 bubble", bubble_o, VEC[k].e_bub);
            chk("R2 exe_valid", exe_valid_o, VEC[k].e_exv);
            if (VEC[k].e_exv) chk("R2 exe_tag", exe_tag_o, VEC[k].e_ext);
            chk("R2 wb_valid", wb_valid_o, VEC[k].e_wbv);
            if (VEC[k].e_wbv) chk("R2 wb_tag", wb_tag_o, VEC[k].e_wbt);
            offer(VEC[k].iv, VEC[k].it, VEC[k].iw, VEC[k].ir, VEC[k].ic);
        end

        // R7: disjoint masks
        offer(1'b1, 8'h51, 6'h01, 6'h00, 1'b0);
        offer(1'b1, 8'h52, 6'h00, 6'h02, 1'b0);
        idle(); idle();
        chk("R7 stall", stall_o, 0);
        chk("R7 mem_tag", mem_tag_o, 8'h52);

        // R9: invalid producer
        offer(1'b0, 8'h61, 6'h01, 6'h00, 1'b0);
        offer(1'b1, 8'h62, 6'h00, 6'h01, 1'b0);
        idle(); idle();
        chk("R9 stall invalid producer", stall_o, 0);
        chk("R9 mem_valid", mem_valid_o, 1);
        // R9: invalid reader
        offer(1'b1, 8'h71, 6'h01, 6'h00, 1'b0);
        offer(1'b0, 8'h72, 6'h00, 6'h01, 1'b0);
        idle(); idle();
        chk("R9 stall invalid reader", stall_o, 0);

        // R11: input offered during a stall is dropped
        offer(1'b1, 8'h31, 6'h02, 6'h00, 1'b0);
        offer(1'b1, 8'h32, 6'h00, 6'h02, 1'b0);
        idle(); idle();
        chk("R3 stall", stall_o, 1);
        offer(1'b1, 8'h33, 6'h00, 6'h00, 1'b0);
        chk("R4 exe_valid", exe_valid_o, 0);
        chk("R4 bubble", bubble_o, 1);
        chk("R4 mem_tag held", mem_tag_o, 8'h32);
        chk("R4 mem_valid held", mem_valid_o, 1);
        chk("R4 wb_tag", wb_tag_o, 8'h31);
        chk("R5 stall released", stall_o, 0);
        idle();
        chk("R5 exe_valid", exe_valid_o, 1);
        chk("R5 exe_tag", exe_tag_o, 8'h32);
        idle();
        chk("R11 mem_valid", mem_valid_o, 0);
        idle();
        chk("R11 exe_valid", exe_valid_o, 0);

        // R10: flush
        offer(1'b1, 8'h41, 6'h00, 6'h00, 1'b0);
        offer(1'b1, 8'h42, 6'h00, 6'h00, 1'b0);
        offer(1'b1, 8'h43, 6'h00, 6'h00, 1'b0);
        chk("R10 mem_valid before", mem_valid_o, 1);
        flush = 1'b1;
        idle();
        flush = 1'b0;
        chk("R10 mem_valid", mem_valid_o, 0);
        chk("R10 exe_valid", exe_valid_o, 0);
        chk("R10 bubble", bubble_o, 0);
        idle();
        chk("R10 exe_valid later", exe_valid_o, 0);
        idle();
        chk("R10 wb_valid later", wb_valid_o, 0);

        // R1: reset while a stall is pending
        offer(1'b1, 8'h81, 6'h20, 6'h00, 1'b0);
        offer(1'b1, 8'h82, 6'h00, 6'h20, 1'b0);
        idle(); idle();
        chk("R3 stall before reset", stall_o, 1);
        rst = 1'b1;
        idle();
        rst = 1'b0;
        chk("R1 stall", stall_o, 0);
        chk("R1 bubble", bubble_o, 0);
        chk("R1 mem_valid", mem_valid_o, 0);
        chk("R1 exe_valid", exe_valid_o, 0);
        chk("R1 wb_valid", wb_valid_o, 0);

        summary();
        $finish;
    end
endmodule